// File: doc/BRIEF.md
# Capture ring writer

This block takes 32-bit samples from an audio capture source, cuts a programmable bit field out of each one, packs four of the resulting 16-bit values into a 64-bit line and queues the lines in a FIFO. When enough lines are waiting, it drains them as a burst of 64-bit writes through a valid/ready memory port into a circular buffer in memory.

Software sets three byte addresses: the ring base, the first word to write, and the last word of the ring. The last-word address is inclusive. A level-sensitive run control copies the first-word address into the live pointer on its rising edge. While it is held low, the writer is stopped. The live pointer is always visible on a status output, so software can compute how far capture has progressed by subtracting the ring base.

Top module: `ring_wr_top`

## Requirements
- R1: Every memory write carries one 64-bit line. After a write that is not at the last ring word, the write address grows by 8.
- R2: A write to the word whose address equals the last-word address is followed by a write to the ring base, so the last word is part of the ring.
- R3: On a rising edge of `run`, the first-word address is copied into the live pointer. The status output shows it from the next cycle.
- R4: A burst starts only when the FIFO holds at least `thresh` lines (a value of 0 acts as 1). Each burst writes exactly that many lines.
- R5: Each sample is shifted right by `fld_lo`. Only bits `fld_hi` down to `fld_lo` are kept (`fld_hi` ≥ `fld_lo`), and of those only the low 16, right-justified and zero-extended.
- R6: Four successive samples form one line. The k-th sample (k = 0..3) lands in bits 16k+15 down to 16k, so the earliest sample is in bits 15:0.
- R7: When a line completes while the FIFO is full, that line is discarded and `ovf` goes high. `ovf` stays high until reset.
- R8: Once `mem_valid` is high, it stays high until `mem_ready` is seen, and address and data stay unchanged.
- R9: While `run` is low, no write is issued and incoming samples are ignored. Queued lines and a partly packed line are discarded, and the live pointer keeps its value.
- R10: The low three bits of the ring base, first-word and last-word addresses are ignored. Each is treated as rounded down to a multiple of 8.
- R11: The status output always equals the address of the next write.
- R12: After reset, `mem_valid` and `ovf` are low and the status output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run control; its rising edge loads the pointer, low stops and flushes |
| ring_base | input | 32 | Byte address of the first word of the ring |
| ring_first | input | 32 | Byte address loaded into the pointer when `run` rises |
| ring_last | input | 32 | Byte address of the last word of the ring, inclusive |
| thresh | input | 8 | FIFO fill level that starts a burst, and the burst length |
| fld_hi | input | 5 | Top bit position of the sample field |
| fld_lo | input | 5 | Bottom bit position of the sample field |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Raw capture sample |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Byte address of the write |
| mem_data | output | 64 | Line being written |
| wr_pos | output | 32 | Live write pointer |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions assume the following about the block's inputs:
- The three addresses, the threshold and the field bounds are steady while `run` is high.
- The threshold never exceeds the FIFO depth.
- `fld_hi` is never below `fld_lo`.

The bench changes configuration only while `run` is low or the writer is idle with an empty FIFO, and always writes `fld_hi` ≥ `fld_lo`. It never drives `thresh` above the default depth of 128.

`mem_ready` is left free: the bench holds it low for long stretches so that back-pressure and the full-FIFO case are both reached.

// File: rtl/ring_wr_pkg.sv
`timescale 1ns/1ps
package ring_wr_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned IN_W       = 32;
    localparam int unsigned SMP_W      = 16;
    localparam int unsigned LINE_W     = 64;
    localparam int unsigned LANES      = LINE_W / SMP_W;
    localparam int unsigned LANE_IW    = $clog2(LANES);
    localparam int unsigned POS_W      = $clog2(IN_W);
    localparam int unsigned POS_W1     = POS_W + 1;
    localparam int unsigned STEP_BYTES = LINE_W / 8;

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(STEP_BYTES - 1);

    typedef enum logic [0:0] {
        WR_IDLE  = 1'b0,
        WR_BURST = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] data;
    } line_t;

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a);
        return a & ALIGN_MASK;
    endfunction

    function automatic logic [SMP_W-1:0] cut_field(
        input logic [IN_W-1:0]  d,
        input logic [POS_W-1:0] hi,
        input logic [POS_W-1:0] lo
    );
        logic [IN_W-1:0]   sh;
        logic [IN_W-1:0]   mask;
        logic [POS_W1-1:0] w;
        sh   = d >> lo;
        w    = {1'b0, hi} - {1'b0, lo} + POS_W1'(1);
        mask = w[POS_W] ? '1 : ((IN_W'(1) << w[POS_W-1:0]) - IN_W'(1));
        return SMP_W'(sh & mask);
    endfunction
endpackage

// File: rtl/ring_wr_pack.sv
`timescale 1ns/1ps
module ring_wr_pack
    import ring_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             smp_valid,
    input  logic [IN_W-1:0]  smp_data,
    input  logic [POS_W-1:0] fld_hi,
    input  logic [POS_W-1:0] fld_lo,
    output line_t            line_out
);
    logic [SMP_W-1:0]   held [LANES-1];
    logic [LANE_IW-1:0] idx;
    logic [SMP_W-1:0]   field;
    logic [LINE_W-1:0]  assembled;

    always_comb field = cut_field(smp_data, fld_hi, fld_lo);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == LANES - 1) begin : g_last
            assign assembled[g*SMP_W +: SMP_W] = field;
        end else begin : g_held
            assign assembled[g*SMP_W +: SMP_W] = held[g];
        end
    end

    always_comb begin
        line_out.vld  = en && smp_valid && (idx == LANE_IW'(LANES - 1));
        line_out.data = assembled;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx <= '0;
        end else if (smp_valid) begin
            if (idx != LANE_IW'(LANES - 1)) begin
                held[idx] <= field;
            end
            idx <= idx + LANE_IW'(1);
        end
    end

    // R6: a line completes only after the three earlier lanes were filled
    p_line_cadence_r6: assert property (@(posedge clk) disable iff (rst)
        (line_out.vld) |=> (idx == '0));
endmodule

// File: rtl/ring_wr_fifo.sv
`timescale 1ns/1ps
module ring_wr_fifo
    import ring_wr_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  line_t             push_line,
    input  logic              pop,
    output logic [LINE_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              ovf
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [LINE_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              do_push;
    logic              do_pop;

    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        empty   = (level == '0);
        do_push = push_line.vld && !full;
        do_pop  = pop && !empty;
        head    = store[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_line.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_line.vld && full) begin
                ovf <= 1'b1;
            end
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                level  <= '0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
                if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
                case ({do_push, do_pop})
                    2'b10:   level <= level + LVL_W'(1);
                    2'b01:   level <= level - LVL_W'(1);
                    default: level <= level;
                endcase
            end
        end
    end

    p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (push_line.vld && full && !flush && !pop) |=> (ovf && level == LVL_W'(DEPTH)));
endmodule

// File: rtl/ring_wr_ctrl.sv
`timescale 1ns/1ps
module ring_wr_ctrl
    import ring_wr_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] ring_first,
    input  logic [ADDR_W-1:0] ring_last,
    input  logic [LVL_W-1:0]  thresh,
    input  logic [LVL_W-1:0]  level,
    input  logic              empty,
    input  logic [LINE_W-1:0] head,
    output logic              pop,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data,
    output logic [ADDR_W-1:0] wr_pos
);
    wr_state_e         state;
    logic [LVL_W-1:0]  left;
    logic [LVL_W-1:0]  eff_thr;
    logic [ADDR_W-1:0] ptr;
    logic              run_q;
    logic              load_edge;
    logic              at_last;
    logic              hs;

    always_comb begin
        eff_thr   = (thresh == '0) ? LVL_W'(1) : thresh;
        load_edge = run && !run_q;
        at_last   = (ptr == align_addr(ring_last));
        mem_valid = run && (state == WR_BURST) && !empty;
        hs        = mem_valid && mem_ready;
        pop       = hs;
        mem_addr  = ptr;
        mem_data  = head;
        wr_pos    = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WR_IDLE;
            left  <= '0;
            ptr   <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= run;
            if (load_edge) begin
                ptr <= align_addr(ring_first);
            end else if (hs) begin
                ptr <= at_last ? align_addr(ring_base) : ptr + ADDR_W'(STEP_BYTES);
            end
            if (!run) begin
                state <= WR_IDLE;
                left  <= '0;
            end else begin
                unique case (state)
                    WR_IDLE: begin
                        if (level >= eff_thr) begin
                            state <= WR_BURST;
                            left  <= eff_thr;
                        end
                    end
                    WR_BURST: begin
                        if (hs) begin
                            left <= left - LVL_W'(1);
                            if (left == LVL_W'(1)) state <= WR_IDLE;
                        end
                    end
                    default: state <= WR_IDLE;
                endcase
            end
        end
    end

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (run && hs && (mem_addr != align_addr(ring_last)))
            |=> (wr_pos == $past(mem_addr) + ADDR_W'(STEP_BYTES)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (run && hs && (mem_addr == align_addr(ring_last)))
            |=> (wr_pos == align_addr($past(ring_base))));

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !run_q) |=> (wr_pos == align_addr($past(ring_first))));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready && run)
            |=> (!run || (mem_valid && $stable(mem_addr) && $stable(mem_data))));

    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (!mem_valid));

    p_aligned_r10: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[2:0] == 3'b000));
endmodule

// File: rtl/ring_wr_top.sv
`timescale 1ns/1ps
module ring_wr_top
    import ring_wr_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] ring_first,
    input  logic [ADDR_W-1:0] ring_last,
    input  logic [LVL_W-1:0]  thresh,
    input  logic [POS_W-1:0]  fld_hi,
    input  logic [POS_W-1:0]  fld_lo,
    input  logic              smp_valid,
    input  logic [IN_W-1:0]   smp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data,
    output logic [ADDR_W-1:0] wr_pos,
    output logic              ovf
);
    line_t             packed_line;
    logic [LINE_W-1:0] head;
    logic [LVL_W-1:0]  level;
    logic              empty;
    logic              pop;

    ring_wr_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .en       (run),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .fld_hi   (fld_hi),
        .fld_lo   (fld_lo),
        .line_out (packed_line)
    );

    ring_wr_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (!run),
        .push_line(packed_line),
        .pop      (pop),
        .head     (head),
        .level    (level),
        .empty    (empty),
        .ovf      (ovf)
    );

    ring_wr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ring_base (ring_base),
        .ring_first(ring_first),
        .ring_last (ring_last),
        .thresh    (thresh),
        .level     (level),
        .empty     (empty),
        .head      (head),
        .pop       (pop),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .wr_pos    (wr_pos)
    );

    p_reset_r12: assert property (@(posedge clk)
        rst |=> (!mem_valid && !ovf && wr_pos == '0));
endmodule

// File: tb/sim_ring_wr_top.sv
`timescale 1ns/1ps
module sim_ring_wr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [31:0] ring_base = '0;
    logic [31:0] ring_first = '0;
    logic [31:0] ring_last = '0;
    logic [7:0]  thresh = 8'd1;
    logic [4:0]  fld_hi = 5'd31;
    logic [4:0]  fld_lo = 5'd16;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [63:0] mem_data;
    logic [31:0] wr_pos;
    logic        ovf;

    int checks = 0;
    int fails  = 0;
    int ncap   = 0;
    logic [63:0] cap_data [256];
    logic [31:0] cap_addr [256];

    always #5 clk = ~clk;

    ring_wr_top u0 (
        .clk(clk), .rst(rst), .run(run),
        .ring_base(ring_base), .ring_first(ring_first), .ring_last(ring_last),
        .thresh(thresh), .fld_hi(fld_hi), .fld_lo(fld_lo),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .wr_pos(wr_pos), .ovf(ovf)
    );

    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (ncap < 256) begin
                cap_data[ncap] = mem_data;
                cap_addr[ncap] = mem_addr;
            end
            ncap = ncap + 1;
        end
    end

    // vector: {sample, fld_hi, fld_lo, expected 16-bit field}   (R5)
    localparam int NVEC = 7;
    localparam logic [57:0] VEC [NVEC] = '{
        {32'hABCD_1234, 5'd31, 5'd16, 16'hABCD},
        {32'hABCD_1234, 5'd15, 5'd0,  16'h1234},
        {32'h00F0_0000, 5'd23, 5'd20, 16'h000F},
        {32'h8765_4321, 5'd19, 5'd8,  16'h0543},
        {32'hFFFF_FFFF, 5'd31, 5'd0,  16'hFFFF},
        {32'h1234_5678, 5'd27, 5'd12, 16'h2345},
        {32'h8000_0000, 5'd31, 5'd31, 16'h0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample(input logic [31:0] d);
        @(posedge clk); #1;
        smp_valid = 1'b1;
        smp_data  = d;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    function automatic logic [31:0] ring_at(input int k);
        return 32'h100 + 32'(8 * ((1 + k) % 4));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        logic [31:0] a1;
        cyc(3);
        @(negedge clk);
        chk("R12 valid", 64'(mem_valid), 64'd0);
        chk("R12 ovf", 64'(ovf), 64'd0);
        chk("R12 pos", 64'(wr_pos), 64'd0);
        rst = 1'b0;

        ring_base = 32'h100; ring_first = 32'h108; ring_last = 32'h118;
        thresh = 8'd1; mem_ready = 1'b1;
        cyc(1);
        run = 1'b1;
        cyc(2);
        @(negedge clk);
        chk("R3 load", 64'(wr_pos), 64'h108);

        for (int i = 0; i < NVEC; i++) begin
            fld_hi = VEC[i][25:21];
            fld_lo = VEC[i][20:16];
            repeat (4) sample(VEC[i][57:26]);
            cyc(6);
            @(negedge clk);
            chk("R5 field", cap_data[i], {4{VEC[i][15:0]}});
            chk("R1 addr", 64'(cap_addr[i]), 64'(ring_at(i)));
            chk("R11 pos", 64'(wr_pos), 64'(ring_at(i + 1)));
        end
        chk("R2 wrap", 64'(cap_addr[3]), 64'h100);

        fld_hi = 5'd15; fld_lo = 5'd0;
        sample(32'h1111); sample(32'h2222); sample(32'h3333); sample(32'h4444);
        cyc(6);
        @(negedge clk);
        chk("R6 lanes", cap_data[7], 64'h4444_3333_2222_1111);
        chk("R2 addr", 64'(cap_addr[7]), 64'(ring_at(7)));

        thresh = 8'd3;
        base = ncap;
        for (int w = 0; w < 2; w++) repeat (4) sample(32'h0000_0021 + 32'(w));
        cyc(10);
        @(negedge clk);
        chk("R4 below", 64'(ncap), 64'(base));
        repeat (4) sample(32'h0000_0077);
        cyc(10);
        @(negedge clk);
        chk("R4 burst", 64'(ncap), 64'(base + 3));
        chk("R1 burst", 64'(wr_pos), 64'(ring_at(11)));

        thresh = 8'd1;
        mem_ready = 1'b0;
        base = ncap;
        sample(32'hA); sample(32'hB); sample(32'hC); sample(32'hD);
        cyc(4);
        @(negedge clk);
        a1 = mem_addr;
        chk("R8 valid", 64'(mem_valid), 64'd1);
        cyc(5);
        @(negedge clk);
        chk("R8 addr", 64'(mem_addr), 64'(a1));
        chk("R8 data", mem_data, 64'h000D_000C_000B_000A);
        mem_ready = 1'b1;
        cyc(4);
        @(negedge clk);
        chk("R8 accept", 64'(ncap), 64'(base + 1));

        sample(32'h1); sample(32'h2);
        run = 1'b0;
        base = ncap;
        repeat (4) sample(32'hDEAD);
        cyc(6);
        @(negedge clk);
        chk("R9 no write", 64'(ncap), 64'(base));
        chk("R9 pos hold", 64'(wr_pos), 64'(ring_at(12)));
        ring_base = 32'h104; ring_first = 32'h11C;
        cyc(1);
        run = 1'b1;
        cyc(3);
        @(negedge clk);
        chk("R10 first", 64'(wr_pos), 64'h118);
        chk("R9 flushed", 64'(ncap), 64'(base));
        sample(32'h5); sample(32'h6); sample(32'h7); sample(32'h8);
        cyc(6);
        @(negedge clk);
        chk("R9 partial dropped", cap_data[base], 64'h0008_0007_0006_0005);
        chk("R10 addr", 64'(cap_addr[base]), 64'h118);
        chk("R10 base", 64'(wr_pos), 64'h100);

        mem_ready = 1'b0;
        thresh = 8'd128;
        base = ncap;
        for (int w = 0; w < 128; w++) repeat (4) sample(32'(w));
        cyc(3);
        @(negedge clk);
        chk("R7 not yet", 64'(ovf), 64'd0);
        repeat (4) sample(32'h55);
        cyc(2);
        @(negedge clk);
        chk("R7 flag", 64'(ovf), 64'd1);
        mem_ready = 1'b1;
        cyc(200);
        @(negedge clk);
        chk("R7 dropped", 64'(ncap), 64'(base + 128));
        chk("R7 sticky", 64'(ovf), 64'd1);

        rst = 1'b1;
        cyc(2);
        @(negedge clk);
        chk("R12 ovf clear", 64'(ovf), 64'd0);
        chk("R12 pos clear", 64'(wr_pos), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule